// File: doc/BRIEF.md
# I2C Slave Address Recogniser

This block is the target-side front end of a two-wire serial peripheral. While enabled it watches the synchronised clock and data lines for a start condition. It then shifts in the seven address bits and the direction bit. The address is compared with a programmable own address and, when software allows it, with the all-zero broadcast address. A match may be acknowledged, sets status flags, can raise an interrupt, and holds the clock line low until software has looked at the status register. Software then reads the captured byte, whose lowest bit tells it whether the master wants to write to it or read from it.

Software reaches the block through a four-entry register port. The entries are control, status, own address and data. A start by the block itself, clock generation and the data bytes after the address are handled elsewhere. The block signals its line activity as open-drain pull-down requests, and the pad logic turns these into pin drive.

Top module: `i2c_addr_slave`

## Requirements
- R1: After reset both pull-down outputs are 0, the status register (select 1) reads 0 and `irq` is 0.
- R2: After a start (SDA falling while SCL is high), eight bits are sampled on SCL rising edges, MSB first. On a match the whole byte is readable from the data register (select 3).
- R3: If bits 7..1 of the byte equal the nonzero own address (select 2, bits 6..0), status bit 0 (event) and bit 1 (matched) become 1.
- R4: If the address does not match, there are no flags, no acknowledge and no stretch. This holds for every later bit, until the next start.
- R5: On a match, `sda_pull` is high during the ninth clock only when control bit 1 (acknowledge enable) is set.
- R6: `irq` is high exactly while the event flag is set and control bit 2 (interrupt enable) is set.
- R7: The address 0 matches only when control bit 3 (broadcast enable) is set. Such a match also sets status bit 3.
- R8: After the falling SCL edge that ends the ninth clock of a match, `scl_pull` is held high until status is read. It drops on the cycle after that read.
- R9: The event, matched and broadcast flags clear when a status read is followed by a data register access. A status read alone leaves them set.
- R10: Bit 0 of the captured byte in the data register gives the direction: 0 means the master writes (slave receives), 1 means the master reads.
- R11: A stop (SDA rising while SCL is high) clears the flags and any stretch, and returns the block to idle.
- R12: With control bit 0 (enable) clear, the block never pulls either line and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line level from the pad |
| sda_in | input | 1 | SDA line level from the pad |
| scl_pull | output | 1 | Request to pull SCL low (clock stretch) |
| sda_pull | output | 1 | Request to pull SDA low (acknowledge) |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 own address, 3 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on status and data) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Interrupt request |

## Verification
The address phase is driven with several bytes:

- the own address with the direction bit clear and set, which separates capture of the full byte from capture of the address alone;
- a foreign address followed by a second byte equal to the own address, which shows that a mismatch really ignores the rest of the transfer rather than re-arming on any byte;
- the zero address with broadcast matching off and on, which separates broadcast matching from own-address matching.

The same own-address pattern is repeated with acknowledge, interrupt and enable bits toggled, to show each gate acting alone. Flag clearing is tried with a lone status read, with a status read followed by a data read, and with a stop. These separate the two-step clear from the stop clear.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

    // control register bit positions
    localparam int unsigned CTRL_EN  = 0;
    localparam int unsigned CTRL_ACK = 1;
    localparam int unsigned CTRL_IRQ = 2;
    localparam int unsigned CTRL_GC  = 3;

    // status register bit positions
    localparam int unsigned STAT_EVT   = 0;
    localparam int unsigned STAT_MATCH = 1;
    localparam int unsigned STAT_GC    = 3;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_OWN  = 2'd2,
        SEL_DATA = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DECIDE,
        ST_ACK,
        ST_HOLD,
        ST_SKIP
    } slv_state_e;

    typedef struct packed {
        logic gc_en;
        logic irq_en;
        logic ack_en;
        logic enable;
    } ctrl_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t d, q;
    logic  scl_lvl;
    logic  sda_lvl;

    assign scl_lvl = q.scl_pipe[STAGES-1];
    assign sda_lvl = q.sda_pipe[STAGES-1];

    always_comb begin
        d          = q;
        d.scl_pipe = {q.scl_pipe[STAGES-2:0], scl_i};
        d.sda_pipe = {q.sda_pipe[STAGES-2:0], sda_i};
        d.scl_prev = scl_lvl;
        d.sda_prev = sda_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{scl_pipe: '1, sda_pipe: '1, scl_prev: 1'b1, sda_prev: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign sda_lvl_o  = sda_lvl;
    assign scl_rise_o = scl_lvl & ~q.scl_prev;
    assign scl_fall_o = ~scl_lvl & q.scl_prev;
    assign start_o    = scl_lvl & q.scl_prev & q.sda_prev & ~sda_lvl;
    assign stop_o     = scl_lvl & q.scl_prev & ~q.sda_prev & sda_lvl;

endmodule

// File: rtl/i2c_addr_fsm.sv
module i2c_addr_fsm
    import i2c_slv_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              ack_en_i,
    input  logic              gc_en_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              sda_lvl_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              stat_rd_i,
    output logic              sda_low_o,
    output logic              scl_low_o,
    output logic              match_evt_o,
    output logic              gc_evt_o,
    output logic              stop_evt_o,
    output logic [ADDR_W:0]   rx_byte_o
);

    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        slv_state_e        state;
        logic [BYTE_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              sda_low;
        logic              scl_low;
        logic              pending;
    } fsm_t;

    fsm_t d, q;
    logic [ADDR_W-1:0] rx_addr;
    logic              own_hit;
    logic              gc_hit;

    assign rx_addr = q.shreg[BYTE_W-1:1];
    assign own_hit = (rx_addr == own_addr_i) && (rx_addr != '0);
    assign gc_hit  = gc_en_i && (rx_addr == '0);

    always_comb begin
        d           = q;
        match_evt_o = 1'b0;
        gc_evt_o    = 1'b0;
        if (!en_i) begin
            d.state   = ST_IDLE;
            d.cnt     = '0;
            d.sda_low = 1'b0;
            d.scl_low = 1'b0;
            d.pending = 1'b0;
        end else begin
            if (stat_rd_i) begin
                d.pending = 1'b0;
            end
            if (stop_i) begin
                d.state   = ST_IDLE;
                d.sda_low = 1'b0;
                d.scl_low = 1'b0;
                d.pending = 1'b0;
            end else if (start_i) begin
                d.state   = ST_ADDR;
                d.cnt     = '0;
                d.sda_low = 1'b0;
                d.scl_low = 1'b0;
                d.pending = 1'b0;
            end else begin
                unique case (q.state)
                    ST_ADDR: begin
                        if (scl_rise_i) begin
                            d.shreg = {q.shreg[BYTE_W-2:0], sda_lvl_i};
                            if (q.cnt == LAST_BIT) begin
                                d.state = ST_DECIDE;
                            end else begin
                                d.cnt = q.cnt + 1'b1;
                            end
                        end
                    end
                    ST_DECIDE: begin
                        if (scl_fall_i) begin
                            if (own_hit || gc_hit) begin
                                d.state     = ST_ACK;
                                d.sda_low   = ack_en_i;
                                d.pending   = 1'b1;
                                match_evt_o = 1'b1;
                                gc_evt_o    = gc_hit && !own_hit;
                            end else begin
                                d.state = ST_SKIP;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall_i) begin
                            d.sda_low = 1'b0;
                            d.state   = ST_HOLD;
                        end
                    end
                    ST_HOLD: begin
                        d.scl_low = q.pending && !stat_rd_i;
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, shreg: '0, cnt: '0,
                   sda_low: 1'b0, scl_low: 1'b0, pending: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sda_low_o  = q.sda_low;
    assign scl_low_o  = q.scl_low;
    assign stop_evt_o = en_i && stop_i;
    assign rx_byte_o  = q.shreg;

    // R5: an acknowledge pull only starts while acknowledge is enabled
    p_ack_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.sda_low) |-> $past(ack_en_i));

    // R8: the stretch is gone on the cycle after a status read
    p_release_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd_i |=> !q.scl_low);

    // R12: a disabled block releases both lines
    p_quiet_when_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!q.sda_low && !q.scl_low));

endmodule

// File: rtl/i2c_slv_regs.sv
module i2c_slv_regs
    import i2c_slv_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      reg_sel_i,
    input  logic            reg_wr_i,
    input  logic            reg_rd_i,
    input  logic [ADDR_W:0] reg_wdata_i,
    output logic [ADDR_W:0] reg_rdata_o,
    input  logic            match_evt_i,
    input  logic            gc_evt_i,
    input  logic            stop_evt_i,
    input  logic [ADDR_W:0] rx_byte_i,
    output ctrl_t           ctrl_o,
    output logic [ADDR_W-1:0] own_addr_o,
    output logic            stat_rd_o,
    output logic            matched_o,
    output logic            irq_o
);

    localparam int BYTE_W = ADDR_W + 1;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [ADDR_W-1:0] own;
        logic [BYTE_W-1:0] data;
        logic              evt;
        logic              matched;
        logic              gcall;
        logic              armed;
    } regs_t;

    regs_t    d, q;
    reg_sel_e sel;
    logic     data_acc;

    assign sel       = reg_sel_e'(reg_sel_i);
    assign stat_rd_o = reg_rd_i && (sel == SEL_STAT);
    assign data_acc  = (reg_rd_i || reg_wr_i) && (sel == SEL_DATA);

    always_comb begin
        d = q;
        if (reg_wr_i) begin
            unique case (sel)
                SEL_CTRL: d.ctrl = ctrl_t'(reg_wdata_i[3:0]);
                SEL_OWN:  d.own  = reg_wdata_i[ADDR_W-1:0];
                SEL_DATA: d.data = reg_wdata_i;
                default: begin
                end
            endcase
        end
        if (stat_rd_o && q.evt) begin
            d.armed = 1'b1;
        end
        if (data_acc && q.armed) begin
            d.evt     = 1'b0;
            d.matched = 1'b0;
            d.gcall   = 1'b0;
            d.armed   = 1'b0;
        end
        if (stop_evt_i) begin
            d.evt     = 1'b0;
            d.matched = 1'b0;
            d.gcall   = 1'b0;
            d.armed   = 1'b0;
        end
        if (match_evt_i) begin
            d.evt     = 1'b1;
            d.matched = 1'b1;
            d.gcall   = gc_evt_i;
            d.armed   = 1'b0;
            d.data    = rx_byte_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ctrl: '0, own: '0, data: '0, evt: 1'b0,
                   matched: 1'b0, gcall: 1'b0, armed: 1'b0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        unique case (sel)
            SEL_CTRL: reg_rdata_o[3:0] = q.ctrl;
            SEL_STAT: begin
                reg_rdata_o[STAT_EVT]   = q.evt;
                reg_rdata_o[STAT_MATCH] = q.matched;
                reg_rdata_o[STAT_GC]    = q.gcall;
            end
            SEL_OWN:  reg_rdata_o[ADDR_W-1:0] = q.own;
            SEL_DATA: reg_rdata_o = q.data;
            default: begin
            end
        endcase
    end

    assign ctrl_o     = q.ctrl;
    assign own_addr_o = q.own;
    assign matched_o  = q.matched;
    assign irq_o      = q.evt && q.ctrl.irq_en;

    // R3: the event flag only rises from an address match
    p_event_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.evt) |-> $past(match_evt_i));

    // R9: the event flag only falls after the two-step clear or a stop
    p_event_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.evt) |-> $past(stop_evt_i || (data_acc && q.armed)));

endmodule

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave
    import i2c_slv_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_in,
    input  logic            sda_in,
    output logic            scl_pull,
    output logic            sda_pull,
    input  logic [1:0]      reg_sel,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [ADDR_W:0] reg_wdata,
    output logic [ADDR_W:0] reg_rdata,
    output logic            irq
);

    logic              sda_lvl;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              stat_rd;
    logic              match_evt;
    logic              gc_evt;
    logic              stop_evt;
    logic              matched;
    logic [ADDR_W:0]   rx_byte;
    logic [ADDR_W-1:0] own_addr;
    ctrl_t             ctrl;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_in),
        .sda_i      (sda_in),
        .sda_lvl_o  (sda_lvl),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    i2c_addr_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (ctrl.enable),
        .ack_en_i    (ctrl.ack_en),
        .gc_en_i     (ctrl.gc_en),
        .own_addr_i  (own_addr),
        .sda_lvl_i   (sda_lvl),
        .scl_rise_i  (scl_rise),
        .scl_fall_i  (scl_fall),
        .start_i     (start_det),
        .stop_i      (stop_det),
        .stat_rd_i   (stat_rd),
        .sda_low_o   (sda_pull),
        .scl_low_o   (scl_pull),
        .match_evt_o (match_evt),
        .gc_evt_o    (gc_evt),
        .stop_evt_o  (stop_evt),
        .rx_byte_o   (rx_byte)
    );

    i2c_slv_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_sel_i   (reg_sel),
        .reg_wr_i    (reg_wr),
        .reg_rd_i    (reg_rd),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .match_evt_i (match_evt),
        .gc_evt_i    (gc_evt),
        .stop_evt_i  (stop_evt),
        .rx_byte_i   (rx_byte),
        .ctrl_o      (ctrl),
        .own_addr_o  (own_addr),
        .stat_rd_o   (stat_rd),
        .matched_o   (matched),
        .irq_o       (irq)
    );

    // R8: a stretch is only ever held for a matched address
    p_stretch_needs_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        scl_pull |-> matched);

endmodule

// File: tb/i2c_addr_slave_bench.sv
module i2c_addr_slave_bench;

    localparam int HALF = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       scl_pull, sda_pull, irq;
    logic [1:0] reg_sel = 2'd0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       scl_bus, sda_bus;
    int         checks = 0;
    int         errors = 0;
    logic       done = 1'b0;

    always #10 clk = ~clk;

    assign scl_bus = scl_m & ~scl_pull;
    assign sda_bus = sda_m & ~sda_pull;

    i2c_addr_slave u_i2c_addr_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_bus),
        .sda_in    (sda_bus),
        .scl_pull  (scl_pull),
        .sda_pull  (sda_pull),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        reg_sel = sel; reg_wdata = val; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] sel, output logic [7:0] val);
        @(negedge clk);
        reg_sel = sel; reg_rd = 1'b1;
        #1 val = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wait_cyc(HALF);
        sda_m = 1'b0; wait_cyc(HALF);
        scl_m = 1'b0; wait_cyc(HALF);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_cyc(HALF);
        scl_m = 1'b1; wait_cyc(HALF);
        sda_m = 1'b1; wait_cyc(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_cyc(HALF);
            scl_m = 1'b1; wait_cyc(HALF);
            scl_m = 1'b0;
        end
    endtask

    task automatic ack_slot(output logic acked);
        sda_m = 1'b1; wait_cyc(HALF);
        scl_m = 1'b1; wait_cyc(HALF / 2);
        acked = sda_pull;
        wait_cyc(HALF / 2);
        scl_m = 1'b0; wait_cyc(HALF);
    endtask

    task automatic addr_phase(input logic [7:0] b, output logic acked);
        bus_start();
        send_byte(b);
        ack_slot(acked);
    endtask

    // status then data read: releases stretch and clears flags
    task automatic clear_flags();
        logic [7:0] v;
        reg_read(2'd1, v);
        reg_read(2'd3, v);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 scl_pull", {7'd0, scl_pull}, 8'h00);
        check("R1 sda_pull", {7'd0, sda_pull}, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        reg_read(2'd1, v);
        check("R1 status", v, 8'h00);
    endtask

    task automatic t_write_match();
        logic acked;
        logic [7:0] v;
        reg_write(2'd0, 8'h07);
        addr_phase(8'hA4, acked);
        check("R5 ack driven", {7'd0, acked}, 8'h01);
        check("R8 stretch held", {7'd0, scl_pull}, 8'h01);
        check("R6 irq raised", {7'd0, irq}, 8'h01);
        reg_read(2'd1, v);
        check("R3 status after match", v, 8'h03);
        check("R8 released after read", {7'd0, scl_pull}, 8'h00);
        reg_read(2'd1, v);
        check("R9 lone status read keeps flags", v, 8'h03);
        reg_read(2'd3, v);
        check("R2 captured byte", v, 8'hA4);
        check("R10 direction receive", {7'd0, v[0]}, 8'h00);
        reg_read(2'd1, v);
        check("R9 flags cleared", v, 8'h00);
        check("R6 irq cleared", {7'd0, irq}, 8'h00);
        bus_stop();
    endtask

    task automatic t_read_dir();
        logic acked;
        logic [7:0] v;
        addr_phase(8'hA5, acked);
        reg_read(2'd1, v);
        reg_read(2'd3, v);
        check("R2 captured read byte", v, 8'hA5);
        check("R10 direction transmit", {7'd0, v[0]}, 8'h01);
        bus_stop();
    endtask

    task automatic t_stop_clears();
        logic acked;
        logic [7:0] v;
        addr_phase(8'hA4, acked);
        reg_read(2'd1, v);
        check("R11 flags before stop", v, 8'h03);
        bus_stop();
        reg_read(2'd1, v);
        check("R11 stop clears flags", v, 8'h00);
        check("R11 no stretch after stop", {7'd0, scl_pull}, 8'h00);
    endtask

    task automatic t_mismatch();
        logic acked;
        logic [7:0] v;
        addr_phase(8'hB0, acked);
        check("R4 no ack on mismatch", {7'd0, acked}, 8'h00);
        check("R4 no stretch on mismatch", {7'd0, scl_pull}, 8'h00);
        send_byte(8'hA4);
        ack_slot(acked);
        check("R4 later own byte ignored", {7'd0, acked}, 8'h00);
        reg_read(2'd1, v);
        check("R4 no flags", v, 8'h00);
        bus_stop();
    endtask

    task automatic t_no_ack();
        logic acked;
        logic [7:0] v;
        reg_write(2'd0, 8'h05);
        addr_phase(8'hA4, acked);
        check("R5 ack suppressed", {7'd0, acked}, 8'h00);
        check("R8 stretch without ack", {7'd0, scl_pull}, 8'h01);
        reg_read(2'd1, v);
        check("R3 flags without ack", v, 8'h03);
        reg_read(2'd3, v);
        bus_stop();
    endtask

    task automatic t_irq_off();
        logic acked;
        logic [7:0] v;
        reg_write(2'd0, 8'h03);
        addr_phase(8'hA4, acked);
        check("R6 irq masked", {7'd0, irq}, 8'h00);
        reg_read(2'd1, v);
        check("R6 event still set", v, 8'h03);
        reg_read(2'd3, v);
        bus_stop();
    endtask

    task automatic t_gcall();
        logic acked;
        logic [7:0] v;
        reg_write(2'd0, 8'h07);
        addr_phase(8'h00, acked);
        check("R7 zero address ignored", {7'd0, acked}, 8'h00);
        reg_read(2'd1, v);
        check("R7 no flags when off", v, 8'h00);
        bus_stop();
        reg_write(2'd0, 8'h0F);
        addr_phase(8'h00, acked);
        check("R7 zero address acked", {7'd0, acked}, 8'h01);
        reg_read(2'd1, v);
        check("R7 broadcast flag", v, 8'h0B);
        reg_read(2'd3, v);
        reg_read(2'd1, v);
        check("R9 broadcast flag cleared", v, 8'h00);
        bus_stop();
    endtask

    task automatic t_disabled();
        logic acked;
        logic [7:0] v;
        reg_write(2'd0, 8'h0E);
        addr_phase(8'hA4, acked);
        check("R12 no ack when off", {7'd0, acked}, 8'h00);
        check("R12 no stretch when off", {7'd0, scl_pull}, 8'h00);
        reg_read(2'd1, v);
        check("R12 no flags when off", v, 8'h00);
        check("R12 no irq when off", {7'd0, irq}, 8'h00);
        bus_stop();
    endtask

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(5);
        t_reset();
        reg_write(2'd2, 8'h52);
        t_write_match();
        t_read_dir();
        t_stop_clears();
        t_mismatch();
        t_no_ack();
        t_irq_off();
        t_gcall();
        t_disabled();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule